// File: doc/BRIEF.md
# Locked Compare-and-Swap Unit

This unit carries out a single atomic compare-and-swap for operand widths of 8, 16, 32 or 64 bits. A request supplies the accumulator, a source value and an operand size. It also says whether the destination lives in memory or in a register, and whether the operation must be locked. The unit compares the low bits of the accumulator with the destination. If they match, the source replaces the destination. If they differ, the destination value is loaded into the accumulator and also written back unchanged to the destination.

A memory destination is reached through a simple request/acknowledge port. That port carries a lock line, which stays high from the read through the acknowledged write, so every locked read is followed by a locked write. A register destination is handed in with the request, and its new value comes out with a one-cycle write strobe. The arithmetic flags are produced as a compare instruction would produce them. A lock request aimed at a register destination is rejected with an invalid-opcode fault.

Top module: `cas_unit`

## Requirements
- R1: `req_size` selects the operand width: 0 means 8 bits, 1 means 16, 2 means 32 and 3 means 64. Only the low bits of that width take part in the comparison. Destination bits above the width are written back unchanged.
- R2: When the low bits are equal, the destination receives the low bits of `src_in` and `flags_out[3]` (ZF) is 1. `acc_we` stays 0.
- R3: When the low bits differ, `acc_we` pulses with `done`. `acc_out` carries the old destination low bits with the upper accumulator bits unchanged. ZF is 0, and the old destination value is written back to the destination.
- R4: A memory destination sees exactly one read, then exactly one write, in every outcome. The write happens whether or not the compare matches.
- R5: For a locked memory operation, `mem_lock` is high continuously from the first read request until the write is acknowledged, and it is low in the cycle after that acknowledge.
- R6: `flags_out[0]` (CF) is the unsigned borrow of accumulator minus destination at the selected width. `flags_out[4]` (SF) is the top bit of that difference. `flags_out[5]` (OF) is its signed overflow.
- R7: `flags_out[2]` (AF) is the borrow out of bit 3. `flags_out[1]` (PF) is 1 when the low 8 bits of the difference hold an even number of ones.
- R8: A locked request with a register destination pulses `ud_fault` together with `done`. It makes no memory access, does not strobe `acc_we` or `dest_reg_we`, and leaves `flags_out` unchanged.
- R9: A register destination causes no memory traffic. `dest_reg_we` pulses with `done`, and `dest_wdata` holds the new destination value.
- R10: `done` is a one-cycle pulse. `req_valid` is ignored while `busy` is high.
- R11: After reset, `busy`, `done`, `mem_req`, `mem_lock`, `acc_we` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an operation (taken only while idle) |
| req_size | input | 2 | Operand width code |
| req_lock | input | 1 | Locked operation requested |
| req_mem | input | 1 | Destination is in memory |
| acc_in | input | 64 | Accumulator value |
| src_in | input | 64 | Source value |
| reg_dest_in | input | 64 | Destination value for a register operand |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_lock | output | 1 | Bus lock held |
| mem_rdata | input | 64 | Memory read data |
| mem_ack | input | 1 | Memory access complete |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Completion pulse |
| ud_fault | output | 1 | Invalid-opcode fault |
| acc_out | output | 64 | New accumulator value |
| acc_we | output | 1 | Accumulator write strobe |
| dest_wdata | output | 64 | Destination write data, for memory and register |
| dest_reg_we | output | 1 | Register destination write strobe |
| flags_out | output | 6 | {OF, SF, ZF, AF, PF, CF} |

## Verification
A failed compare on a register destination loads the accumulator and writes the destination register in the same completion cycle. The accumulator gets the old destination, and the register gets that old value back. The sweep produces such collisions by pairing unequal operands with register destinations at every width. It then checks that both strobes appear together and that each carries its own correct data. For memory operations, the bench also pulses a stray request while the unit is busy. It confirms that this request changes neither the outcome nor the single read/write pair.

// File: rtl/cas_pkg.sv
package cas_pkg;
    localparam int CAS_W     = 64;
    localparam int SIZE_W    = 2;
    localparam int NUM_SIZES = 1 << SIZE_W;
    localparam int FLAG_W    = 6;

    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_AF = 2;
    localparam int FL_ZF = 3;
    localparam int FL_SF = 4;
    localparam int FL_OF = 5;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_CMP   = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4,
        ST_FAULT = 3'd5
    } cas_state_e;

    typedef struct packed {
        cas_state_e          st;
        logic [SIZE_W-1:0]   size;
        logic                lock;
        logic                mem;
        logic [CAS_W-1:0]    acc;
        logic [CAS_W-1:0]    src;
        logic [CAS_W-1:0]    dest;
        logic [CAS_W-1:0]    wdata;
        logic [CAS_W-1:0]    acc_new;
        logic                eq;
        logic [FLAG_W-1:0]   flags;
    } cas_regs_t;
endpackage

// File: rtl/cas_size_mask.sv
module cas_size_mask #(
    parameter int W      = cas_pkg::CAS_W,
    parameter int SIZE_W = cas_pkg::SIZE_W
) (
    input  logic [SIZE_W-1:0] size,
    output logic [W-1:0]      mask
);
    localparam int NSZ = 1 << SIZE_W;

    logic [W-1:0] tab [NSZ];

    for (genvar g = 0; g < NSZ; g++) begin : g_tab
        localparam int BITS = 8 << g;
        assign tab[g] = {W{1'b1}} >> (W - BITS);
    end

    assign mask = tab[size];
endmodule

// File: rtl/cas_merge.sv
module cas_merge #(
    parameter int W = cas_pkg::CAS_W
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] value,
    input  logic [W-1:0] mask,
    output logic [W-1:0] merged
);
    assign merged = (base & ~mask) | (value & mask);
endmodule

// File: rtl/cas_flag_gen.sv
module cas_flag_gen #(
    parameter int W      = cas_pkg::CAS_W,
    parameter int SIZE_W = cas_pkg::SIZE_W
) (
    input  logic [W-1:0]              lhs,
    input  logic [W-1:0]              rhs,
    input  logic [W-1:0]              mask,
    input  logic [SIZE_W-1:0]         size,
    output logic                      equal,
    output logic [cas_pkg::FLAG_W-1:0] flags
);
    import cas_pkg::*;
    localparam int NSZ = 1 << SIZE_W;

    logic [W-1:0]   lm, rm;
    logic [W:0]     diff;
    logic [NSZ-1:0] top_d, top_l, top_r;
    logic           sd, sl, sr;
    logic [4:0]     nib;

    assign lm   = lhs & mask;
    assign rm   = rhs & mask;
    assign diff = {1'b0, lm} - {1'b0, rm};
    assign nib  = {1'b0, lm[3:0]} - {1'b0, rm[3:0]};

    for (genvar g = 0; g < NSZ; g++) begin : g_top
        localparam int MSB = (8 << g) - 1;
        assign top_d[g] = diff[MSB];
        assign top_l[g] = lm[MSB];
        assign top_r[g] = rm[MSB];
    end

    assign sd = top_d[size];
    assign sl = top_l[size];
    assign sr = top_r[size];

    always_comb begin
        equal        = (lm == rm);
        flags        = '0;
        flags[FL_CF] = diff[W];
        flags[FL_PF] = ~^diff[7:0];
        flags[FL_AF] = nib[4];
        flags[FL_ZF] = equal;
        flags[FL_SF] = sd;
        flags[FL_OF] = (sl != sr) && (sd != sl);
    end
endmodule

// File: rtl/cas_unit.sv
module cas_unit
    import cas_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic                 req_lock,
    input  logic                 req_mem,
    input  logic [CAS_W-1:0]     acc_in,
    input  logic [CAS_W-1:0]     src_in,
    input  logic [CAS_W-1:0]     reg_dest_in,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_lock,
    input  logic [CAS_W-1:0]     mem_rdata,
    input  logic                 mem_ack,
    output logic                 busy,
    output logic                 done,
    output logic                 ud_fault,
    output logic [CAS_W-1:0]     acc_out,
    output logic                 acc_we,
    output logic [CAS_W-1:0]     dest_wdata,
    output logic                 dest_reg_we,
    output logic [FLAG_W-1:0]    flags_out
);
    cas_regs_t r_d, r_q;

    logic [CAS_W-1:0]  mask;
    logic [CAS_W-1:0]  dest_if_eq;
    logic [CAS_W-1:0]  acc_if_ne;
    logic              cmp_eq;
    logic [FLAG_W-1:0] cmp_flags;

    cas_size_mask #(.W(CAS_W), .SIZE_W(SIZE_W)) i_mask (
        .size (r_q.size),
        .mask (mask)
    );

    cas_merge #(.W(CAS_W)) i_merge_dest (
        .base   (r_q.dest),
        .value  (r_q.src),
        .mask   (mask),
        .merged (dest_if_eq)
    );

    cas_merge #(.W(CAS_W)) i_merge_acc (
        .base   (r_q.acc),
        .value  (r_q.dest),
        .mask   (mask),
        .merged (acc_if_ne)
    );

    cas_flag_gen #(.W(CAS_W), .SIZE_W(SIZE_W)) i_flags (
        .lhs   (r_q.acc),
        .rhs   (r_q.dest),
        .mask  (mask),
        .size  (r_q.size),
        .equal (cmp_eq),
        .flags (cmp_flags)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.size = req_size;
                    r_d.lock = req_lock;
                    r_d.mem  = req_mem;
                    r_d.acc  = acc_in;
                    r_d.src  = src_in;
                    r_d.dest = reg_dest_in;
                    if (req_lock && !req_mem) begin
                        r_d.st = ST_FAULT;
                    end else if (req_mem) begin
                        r_d.st = ST_READ;
                    end else begin
                        r_d.st = ST_CMP;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    r_d.dest = mem_rdata;
                    r_d.st   = ST_CMP;
                end
            end
            ST_CMP: begin
                r_d.eq      = cmp_eq;
                r_d.flags   = cmp_flags;
                r_d.wdata   = cmp_eq ? dest_if_eq : r_q.dest;
                r_d.acc_new = cmp_eq ? r_q.acc : acc_if_ne;
                r_d.st      = r_q.mem ? ST_WRITE : ST_DONE;
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    r_d.st = ST_DONE;
                end
            end
            ST_DONE:  r_d.st = ST_IDLE;
            ST_FAULT: r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign done        = (r_q.st == ST_DONE) || (r_q.st == ST_FAULT);
    assign ud_fault    = (r_q.st == ST_FAULT);
    assign mem_req     = (r_q.st == ST_READ) || (r_q.st == ST_WRITE);
    assign mem_we      = (r_q.st == ST_WRITE);
    assign mem_lock    = r_q.lock && ((r_q.st == ST_READ) || (r_q.st == ST_CMP) ||
                                      (r_q.st == ST_WRITE));
    assign acc_we      = (r_q.st == ST_DONE) && !r_q.eq;
    assign acc_out     = r_q.acc_new;
    assign dest_wdata  = r_q.wdata;
    assign dest_reg_we = (r_q.st == ST_DONE) && !r_q.mem;
    assign flags_out   = r_q.flags;
endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_req,
    input logic       mem_we,
    input logic       mem_ack,
    input logic       mem_lock,
    input logic       done,
    input logic       ud_fault,
    input logic       acc_we,
    input logic       dest_reg_we,
    input logic [5:0] flags_out
);
    logic read_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            read_open <= 1'b0;
        end else if (mem_req && mem_ack) begin
            read_open <= !mem_we;
        end
    end

    assert_read_paired_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !read_open);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we));

    assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock && !(mem_we && mem_ack) |=> mem_lock);

    assert_lock_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock && mem_we && mem_ack |=> !mem_lock);

    assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> !mem_req && !acc_we && !dest_reg_we && $stable(flags_out));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_zf_vs_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done && !ud_fault |-> flags_out[3] != acc_we);

    assert_load_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> done);
endmodule

bind cas_unit cas_unit_chk i_cas_unit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_lock    (mem_lock),
    .done        (done),
    .ud_fault    (ud_fault),
    .acc_we      (acc_we),
    .dest_reg_we (dest_reg_we),
    .flags_out   (flags_out)
);

// File: tb/test_cas_unit.sv
module test_cas_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_size = '0;
    logic        req_lock = 1'b0;
    logic        req_mem = 1'b0;
    logic [63:0] acc_in = '0;
    logic [63:0] src_in = '0;
    logic [63:0] reg_dest_in = '0;
    logic        mem_req, mem_we, mem_lock;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        busy, done, ud_fault, acc_we, dest_reg_we;
    logic [63:0] acc_out, dest_wdata;
    logic [5:0]  flags_out;

    int checks = 0;
    int errors = 0;

    logic [63:0] mem_word = '0;
    int          mem_lat = 0;
    int          lat_cnt = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [63:0] wr_data = '0;
    logic        lock_rd = 1'b0;
    logic        lock_wr = 1'b0;
    logic        lock_gap = 1'b0;

    always #2.5 clk = ~clk;

    cas_unit i_cas_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
        .req_lock(req_lock), .req_mem(req_mem), .acc_in(acc_in), .src_in(src_in),
        .reg_dest_in(reg_dest_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_lock(mem_lock), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .ud_fault(ud_fault), .acc_out(acc_out),
        .acc_we(acc_we), .dest_wdata(dest_wdata), .dest_reg_we(dest_reg_we),
        .flags_out(flags_out)
    );

    // memory responder, acting on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (rd_cnt > wr_cnt && !mem_lock && lock_rd) lock_gap = 1'b1;
            if (mem_ack) begin
                mem_ack = 1'b0;
                lat_cnt = 0;
            end else if (mem_req) begin
                if (lat_cnt >= mem_lat) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        wr_cnt++;
                        wr_data  = dest_wdata;
                        mem_word = dest_wdata;
                        lock_wr  = mem_lock;
                    end else begin
                        rd_cnt++;
                        mem_rdata = mem_word;
                        lock_rd   = mem_lock;
                    end
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mask_of(input int sz);
        return {64{1'b1}} >> (64 - (8 << sz));
    endfunction

    task automatic run_op(input int sz, input bit lock, input bit mem, input int lat,
                          input logic [63:0] acc, input logic [63:0] src,
                          input logic [63:0] dest);
        logic [63:0] m, a, b, d, nv, exp_dest, exp_acc;
        logic [5:0]  exp_fl, prev_fl;
        bit          eq, fault;
        int          w, waitc;
        m = mask_of(sz);
        w = 8 << sz;
        a = acc & m;
        b = dest & m;
        d = (a - b) & m;
        eq = (a == b);
        fault = lock && !mem;
        nv = eq ? (src & m) : b;
        exp_dest = (dest & ~m) | nv;
        exp_acc  = (acc & ~m) | b;
        exp_fl[0] = a < b;
        exp_fl[1] = ~^d[7:0];
        exp_fl[2] = a[3:0] < b[3:0];
        exp_fl[3] = eq;
        exp_fl[4] = d[w-1];
        exp_fl[5] = (a[w-1] != b[w-1]) && (d[w-1] != a[w-1]);

        @(negedge clk);
        prev_fl = flags_out;
        rd_cnt = 0; wr_cnt = 0; lock_rd = 0; lock_wr = 0; lock_gap = 0;
        mem_lat = lat; mem_word = dest;
        req_valid = 1'b1; req_size = 2'(sz); req_lock = lock; req_mem = mem;
        acc_in = acc; src_in = src; reg_dest_in = mem ? ~dest : dest;
        @(negedge clk);
        // stray request while busy: must be ignored (R10)
        req_valid = 1'b1; req_size = 2'(3 - sz); req_lock = ~lock; req_mem = ~mem;
        acc_in = ~acc; src_in = ~src; reg_dest_in = 64'h0;
        waitc = 0;
        while (!done && waitc < 40) begin
            @(negedge clk);
            req_valid = 1'b0;
            waitc++;
        end
        req_valid = 1'b0;
        check(done, "R10 done arrives", 64'(done), 64'd1);
        check(ud_fault == fault, "R8 fault indication", 64'(ud_fault), 64'(fault));
        if (fault) begin
            check(!acc_we && !dest_reg_we && rd_cnt == 0 && wr_cnt == 0,
                  "R8 no write on fault", 64'(rd_cnt + wr_cnt), 64'd0);
            check(flags_out == prev_fl, "R8 flags unchanged", 64'(flags_out), 64'(prev_fl));
        end else begin
            check(acc_we == !eq, "R3 accumulator strobe", 64'(acc_we), 64'(!eq));
            if (!eq) check(acc_out == exp_acc, "R3 accumulator value", acc_out, exp_acc);
            check(flags_out[3] == exp_fl[3], "R2 ZF", 64'(flags_out[3]), 64'(exp_fl[3]));
            check(flags_out[0] == exp_fl[0] && flags_out[4] == exp_fl[4] &&
                  flags_out[5] == exp_fl[5], "R6 CF/SF/OF", 64'(flags_out), 64'(exp_fl));
            check(flags_out[1] == exp_fl[1] && flags_out[2] == exp_fl[2],
                  "R7 AF/PF", 64'(flags_out), 64'(exp_fl));
            if (mem) begin
                check(rd_cnt == 1 && wr_cnt == 1, "R4 one read one write",
                      64'(rd_cnt * 16 + wr_cnt), 64'h11);
                check(wr_data == exp_dest, "R1 memory write data", wr_data, exp_dest);
                check(!dest_reg_we, "R9 no register strobe for memory", 64'(dest_reg_we), 64'd0);
                if (lock)
                    check(lock_rd && lock_wr && !lock_gap, "R5 lock held",
                          64'({lock_rd, lock_wr, lock_gap}), 64'b110);
                else
                    check(!lock_rd && !lock_wr, "R5 no lock when unrequested",
                          64'({lock_rd, lock_wr}), 64'b00);
            end else begin
                check(rd_cnt == 0 && wr_cnt == 0, "R9 no memory traffic",
                      64'(rd_cnt + wr_cnt), 64'd0);
                check(dest_reg_we, "R9 register strobe", 64'(dest_reg_we), 64'd1);
                check(dest_wdata == exp_dest, "R9 register write data", dest_wdata, exp_dest);
            end
        end
        @(negedge clk);
        check(!done && !busy, "R10 one-cycle done", 64'({done, busy}), 64'd0);
        if (lock && mem)
            check(!mem_lock, "R5 lock released", 64'(mem_lock), 64'd0);
    endtask

    function automatic logic [63:0] special(input int k, input int sz);
        logic [63:0] m;
        m = mask_of(sz);
        case (k)
            0: return 64'd0;
            1: return 64'd1;
            2: return m >> 1;
            3: return (m >> 1) + 64'd1;
            4: return m;
            default: return 64'h18;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req && !mem_lock && !acc_we && flags_out == 0,
              "R11 reset state", 64'({busy, done, mem_req, mem_lock, acc_we}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R11 idle after reset", 64'({busy, done}), 64'd0);

        for (int sz = 0; sz < 4; sz++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    logic [63:0] av, dv, sv;
                    av = 64'hA5C3_9E17_4B2D_6F81 & ~mask_of(sz) | special(i, sz);
                    dv = 64'h5A3C_61E8_B4D2_907E & ~mask_of(sz) | special(j, sz);
                    sv = 64'h0123_4567_89AB_CDEF ^ 64'(i * 7 + j);
                    run_op(sz, (i + j) % 3 == 0, (i + j) % 2 == 1, (i * 2 + j) % 3,
                           av, sv, dv);
                end
            end
            // illegal lock on a register destination (R8)
            run_op(sz, 1'b1, 1'b0, 0, special(1, sz), 64'hFF, special(2, sz));
            // locked memory, equal operands (R2, R4, R5)
            run_op(sz, 1'b1, 1'b1, 2, special(3, sz), 64'hDEAD_BEEF_CAFE_F00D,
                   special(3, sz));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule